// File: doc/BRIEF.md
# Privileged Cycle Counter and Interval Timer

This block holds two 54-bit counters that advance by one on every clock: a time-of-day clock and an interval timer. Both sit in a small register space, selected by a register address. Any mode may read them. Only kernel mode may change them. A write attempted from user mode is refused: the counter keeps counting and the block raises a one-cycle privilege-violation pulse. When the interval timer rolls from all ones to zero, the block raises a one-cycle expiry pulse. An interrupt output is asserted whenever either event pulse is high.

Reads come out in two forms. The full read is a 64-bit word whose top ten bits are always zero. The transfer read is the high-order 32-bit word of that full read. Writes also come in two forms. A full load writes the whole counter. A transfer write carries only a 32-bit high-order word. A kernel write takes effect at the clock edge and wins over that edge's increment. Counting then continues from the written value.

Top module: `cycTimerRegs`

## Requirements
- R1: With no honoured write, each counter increases by exactly one on every clock edge, wrapping from all ones to zero.
- R2: Address 53 selects the time-of-day clock and address 54 selects the interval timer. Any other address reads as zero. A write to any other address changes nothing and raises no violation.
- R3: Reads are allowed in both user and kernel mode and have no side effect on either counter.
- R4: A kernel-mode full load (wrLoad high, kernelMode high) of the selected counter makes the counter equal wrData[53:0] after that edge, overriding the increment. The counter increments from that value on the following edges.
- R5: A write of either form to address 53 or 54 with kernelMode low leaves the counter counting as if no write occurred. privViol is high for exactly the one cycle after that edge.
- R6: timerExpired is high for exactly the one cycle in which the interval timer reads zero after incrementing from all ones.
- R7: A timer value of zero reached by a kernel write raises no expiry. A kernel write to the timer on the edge where it holds all ones also suppresses the expiry.
- R8: rdData[63:54] is always zero and rdData[53:0] is the selected counter.
- R9: xferRdData equals rdData[63:32].
- R10: A kernel transfer write (wrXfer high) sets counter bits [53:32] to xferData[21:0] and clears counter bits [31:0].
- R11: When wrLoad and wrXfer are both high, the full load wins.
- R12: Reset clears both counters and holds timerExpired, privViol and irq low. A reset that arrives while the timer is near wrap raises no expiry.
- R13: irq is high exactly when timerExpired or privViol is high, including both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selAddr | input | 6 | Register address for reads and writes |
| kernelMode | input | 1 | High when the requester runs in kernel mode |
| wrLoad | input | 1 | Full 64-bit load strobe |
| wrXfer | input | 1 | High-word transfer write strobe |
| wrData | input | 64 | Data for a full load |
| xferData | input | 32 | High-order word for a transfer write |
| rdData | output | 64 | Full read of the selected register |
| xferRdData | output | 32 | High-order word of the full read |
| timerExpired | output | 1 | One-cycle pulse on timer wrap to zero |
| privViol | output | 1 | One-cycle pulse after a refused user write |
| irq | output | 1 | Interrupt, high while either pulse is high |

## Verification
Two pairs of events can fall on the same edge. The first pair is a write against the increment. The bench parks the timer at all ones and then writes it exactly on the wrapping edge. A kernel write must replace the value and suppress the expiry. A user write must let the wrap and its expiry happen. The second pair is that user write, which raises a violation in the same cycle as the expiry, so irq must be high for that single cycle. The bench judges every cycle against a behavioural model that tracks both counters and both pulses.

// File: rtl/cycTimerPkg.sv
package cycTimerPkg;
  // strobes from control to datapath, one cycle, combinational
  typedef struct packed {
    logic todWr;    // honoured write to the time-of-day clock
    logic tmrWr;    // honoured write to the interval timer
    logic useXfer;  // write carries only the high-order word
  } ctStrobe_t;
endpackage

// File: rtl/cycTimerCounter.sv
module cycTimerCounter #(
  parameter int W = 54
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadEn,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (loadEn) cnt <= loadVal;
    else             cnt <= cnt + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/cycTimerCtrl.sv
module cycTimerCtrl
  import cycTimerPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int TOD_ADDR = 53,
  parameter int TMR_ADDR = 54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic              kernelMode,
  input  logic              wrLoad,
  input  logic              wrXfer,
  output ctStrobe_t         strobes,
  output logic              privViol
);
  localparam logic [ADDR_W-1:0] TodSel = ADDR_W'(TOD_ADDR);
  localparam logic [ADDR_W-1:0] TmrSel = ADDR_W'(TMR_ADDR);

  logic hitTod, hitTmr, wrAttempt, honoured;

  always_comb begin
    hitTod    = (selAddr == TodSel);
    hitTmr    = (selAddr == TmrSel);
    wrAttempt = (wrLoad || wrXfer) && (hitTod || hitTmr);
    honoured  = wrAttempt && kernelMode;
    strobes.todWr   = honoured && hitTod;
    strobes.tmrWr   = honoured && hitTmr;
    strobes.useXfer = !wrLoad;   // full load wins when both are high
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privViol <= 1'b0;
    else       privViol <= wrAttempt && !kernelMode;
  end
endmodule

// File: rtl/cycTimerDatapath.sv
module cycTimerDatapath
  import cycTimerPkg::*;
#(
  parameter int CNT_W    = 54,
  parameter int DATA_W   = 64,
  parameter int XFER_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int TOD_ADDR = 53,
  parameter int TMR_ADDR = 54
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctStrobe_t         strobes,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [XFER_W-1:0] xferData,
  output logic [CNT_W-1:0]  todVal,
  output logic [CNT_W-1:0]  tmrVal,
  output logic [DATA_W-1:0] rdData,
  output logic [XFER_W-1:0] xferRdData,
  output logic              timerExpired
);
  localparam int PadW   = DATA_W - CNT_W;   // zero bits above a counter
  localparam int LowW   = DATA_W - XFER_W;  // bits below the transfer word
  localparam int XHiW   = CNT_W - LowW;     // counter bits reached by a transfer
  localparam int NumCnt = 2;
  localparam logic [ADDR_W-1:0] TodSel = ADDR_W'(TOD_ADDR);
  localparam logic [ADDR_W-1:0] TmrSel = ADDR_W'(TMR_ADDR);

  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cntVal [NumCnt];
  logic             cntWr  [NumCnt];
  logic             tmrWrap;
  logic             unusedBits;

  assign loadVal = strobes.useXfer ? {xferData[XHiW-1:0], {LowW{1'b0}}}
                                   : wrData[CNT_W-1:0];
  assign unusedBits = ^{wrData[DATA_W-1:CNT_W], xferData[XFER_W-1:XHiW]};

  assign cntWr[0] = strobes.todWr;
  assign cntWr[1] = strobes.tmrWr;

  for (genvar gi = 0; gi < NumCnt; gi++) begin : g_cnt
    cycTimerCounter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .loadEn (cntWr[gi]),
      .loadVal(loadVal),
      .cnt    (cntVal[gi])
    );
  end

  assign todVal = cntVal[0];
  assign tmrVal = cntVal[1];

  // wrap only through the increment path
  assign tmrWrap = !strobes.tmrWr && (&tmrVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerExpired <= 1'b0;
    else       timerExpired <= tmrWrap;
  end

  always_comb begin
    if (selAddr == TodSel)      rdData = {{PadW{1'b0}}, todVal};
    else if (selAddr == TmrSel) rdData = {{PadW{1'b0}}, tmrVal};
    else                        rdData = '0;
    xferRdData = rdData[DATA_W-1:LowW];
  end
endmodule

// File: rtl/cycTimerRegs.sv
module cycTimerRegs
  import cycTimerPkg::*;
#(
  parameter int CNT_W    = 54,
  parameter int DATA_W   = 64,
  parameter int XFER_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int TOD_ADDR = 53,
  parameter int TMR_ADDR = 54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] selAddr,
  input  logic              kernelMode,
  input  logic              wrLoad,
  input  logic              wrXfer,
  input  logic [DATA_W-1:0] wrData,
  input  logic [XFER_W-1:0] xferData,
  output logic [DATA_W-1:0] rdData,
  output logic [XFER_W-1:0] xferRdData,
  output logic              timerExpired,
  output logic              privViol,
  output logic              irq
);
  ctStrobe_t        strobes;
  logic [CNT_W-1:0] todVal, tmrVal;

  cycTimerCtrl #(.ADDR_W(ADDR_W), .TOD_ADDR(TOD_ADDR), .TMR_ADDR(TMR_ADDR)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .selAddr   (selAddr),
    .kernelMode(kernelMode),
    .wrLoad    (wrLoad),
    .wrXfer    (wrXfer),
    .strobes   (strobes),
    .privViol  (privViol)
  );

  cycTimerDatapath #(.CNT_W(CNT_W), .DATA_W(DATA_W), .XFER_W(XFER_W), .ADDR_W(ADDR_W),
                     .TOD_ADDR(TOD_ADDR), .TMR_ADDR(TMR_ADDR)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .selAddr     (selAddr),
    .wrData      (wrData),
    .xferData    (xferData),
    .todVal      (todVal),
    .tmrVal      (tmrVal),
    .rdData      (rdData),
    .xferRdData  (xferRdData),
    .timerExpired(timerExpired)
  );

  assign irq = timerExpired | privViol;
endmodule

// File: rtl/cycTimerChk.sv
module cycTimerChk #(
  parameter int CNT_W    = 54,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 6,
  parameter int TOD_ADDR = 53,
  parameter int TMR_ADDR = 54
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] selAddr,
  input logic              kernelMode,
  input logic              wrLoad,
  input logic              wrXfer,
  input logic [DATA_W-1:0] wrData,
  input logic [CNT_W-1:0]  todVal,
  input logic [CNT_W-1:0]  tmrVal,
  input logic [DATA_W-1:0] rdData,
  input logic              timerExpired,
  input logic              privViol
);
  localparam logic [ADDR_W-1:0] TodSel = ADDR_W'(TOD_ADDR);
  localparam logic [ADDR_W-1:0] TmrSel = ADDR_W'(TMR_ADDR);

  logic anyWr, kTod, kTmr, userHit;
  assign anyWr   = wrLoad || wrXfer;
  assign kTod    = anyWr && kernelMode && (selAddr == TodSel);
  assign kTmr    = anyWr && kernelMode && (selAddr == TmrSel);
  assign userHit = anyWr && !kernelMode && (selAddr == TodSel || selAddr == TmrSel);

  // R1: time-of-day advances by one without a kernel write
  a_r1_tod_counts: assert property (@(posedge clk) disable iff (!rstN)
    !kTod |=> todVal == $past(todVal) + CNT_W'(1));

  // R4: kernel full load to the timer takes the load data
  a_r4_kernel_load: assert property (@(posedge clk) disable iff (!rstN)
    (kTmr && wrLoad) |=> tmrVal == $past(wrData[CNT_W-1:0]));

  // R5: refused user write yields a violation pulse
  a_r5_user_viol: assert property (@(posedge clk) disable iff (!rstN)
    userHit |=> privViol);

  // R5: no violation without a refused user write
  a_r5_viol_cause: assert property (@(posedge clk) disable iff (!rstN)
    !userHit |=> !privViol);

  // R6: wrap through increment raises expiry with zero value
  a_r6_wrap_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ((&tmrVal) && !kTmr) |=> (timerExpired && tmrVal == '0));

  // R7: expiry never seen with a non-zero timer
  a_r7_expiry_zero: assert property (@(posedge clk) disable iff (!rstN)
    timerExpired |-> tmrVal == '0);

  // R8: padding bits of the full read stay zero
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:CNT_W] == '0);
endmodule

bind cycTimerRegs cycTimerChk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .TOD_ADDR(TOD_ADDR), .TMR_ADDR(TMR_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .selAddr(selAddr), .kernelMode(kernelMode),
  .wrLoad(wrLoad), .wrXfer(wrXfer), .wrData(wrData), .todVal(todVal),
  .tmrVal(tmrVal), .rdData(rdData), .timerExpired(timerExpired), .privViol(privViol)
);

// File: tb/cycTimerRegs_tb.sv
`timescale 1ns/1ps
module cycTimerRegs_tb;
  localparam logic [53:0] ALL1 = '1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  selAddr = 6'd53;
  logic        kernelMode = 1'b0;
  logic        wrLoad = 1'b0;
  logic        wrXfer = 1'b0;
  logic [63:0] wrData = '0;
  logic [31:0] xferData = '0;
  wire  [63:0] rdData;
  wire  [31:0] xferRdData;
  wire         timerExpired, privViol, irq;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;
  string curTag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  cycTimerRegs u_dut (
    .clk(clk), .rstN(rstN), .selAddr(selAddr), .kernelMode(kernelMode),
    .wrLoad(wrLoad), .wrXfer(wrXfer), .wrData(wrData), .xferData(xferData),
    .rdData(rdData), .xferRdData(xferRdData), .timerExpired(timerExpired),
    .privViol(privViol), .irq(irq)
  );

  // behavioural reference
  logic [53:0] mTod, mTmr, lv;
  logic        mExp, mViol, hit, att, kT, kM;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTod = '0; mTmr = '0; mExp = 1'b0; mViol = 1'b0;
    end else begin
      hit  = (selAddr == 6'd53) || (selAddr == 6'd54);
      att  = (wrLoad || wrXfer) && hit;
      lv   = wrLoad ? wrData[53:0] : {xferData[21:0], 32'd0};
      kT   = att && kernelMode && selAddr == 6'd53;
      kM   = att && kernelMode && selAddr == 6'd54;
      mExp = (mTmr == ALL1) && !kM;
      mViol = att && !kernelMode;
      mTod = kT ? lv : mTod + 54'd1;
      mTmr = kM ? lv : mTmr + 54'd1;
    end
  end

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [63:0] expRd;
  always @(negedge clk) begin
    if (rstN && running) begin
      expRd = (selAddr == 6'd53) ? {10'd0, mTod} :
              (selAddr == 6'd54) ? {10'd0, mTmr} : 64'd0;
      check64(curTag, rdData, expRd);                 // R8 layout, R1/R2/R3/R4 values
      check64("R9", {32'd0, xferRdData}, {32'd0, expRd[63:32]});
      check64("R6", {63'd0, timerExpired}, {63'd0, mExp});
      check64("R5", {63'd0, privViol}, {63'd0, mViol});
      check64("R13", {63'd0, irq}, {63'd0, mExp | mViol});
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(logic [5:0] a, bit ld, bit xf, bit kern, logic [63:0] d, logic [31:0] x);
    selAddr = a; wrLoad = ld; wrXfer = xf; kernelMode = kern; wrData = d; xferData = x;
    @(negedge clk); #1;
    wrLoad = 1'b0; wrXfer = 1'b0;
  endtask

  task automatic resetChecks();
    check64("R12", rdData, 64'd0);
    check64("R12", {61'd0, timerExpired, privViol, irq}, 64'd0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    resetChecks();                       // R12 at power-up
    #1 rstN = 1'b1; running = 1'b1;

    curTag = "R1";  idle(12);            // R1 free running, R8 zero padding
    curTag = "R3";  selAddr = 6'd54; kernelMode = 1'b0; idle(4);
    kernelMode = 1'b1; idle(4);
    curTag = "R2";  selAddr = 6'd10; idle(2);
    wr(6'd10, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0); idle(1);
    wr(6'd10, 1, 0, 0, 64'h1234, 32'h0); idle(1);
    selAddr = 6'd53; idle(2);

    curTag = "R4";  wr(6'd54, 1, 0, 1, {10'h3FF, ALL1 - 54'd3}, 32'h0); idle(8);
    curTag = "R6";  wr(6'd54, 1, 0, 1, {10'd0, ALL1 - 54'd2}, 32'h0); idle(5);
    curTag = "R7";  wr(6'd54, 1, 0, 1, 64'd0, 32'h0); idle(3);
    wr(6'd54, 1, 0, 1, {10'd0, ALL1 - 54'd1}, 32'h0); idle(1);
    wr(6'd54, 1, 0, 1, 64'd5, 32'h0); idle(4);      // kernel write on wrapping edge
    curTag = "R13"; wr(6'd54, 1, 0, 1, {10'd0, ALL1 - 54'd1}, 32'h0); idle(1);
    wr(6'd54, 1, 0, 0, 64'd7, 32'h0); idle(4);      // user write on wrapping edge
    curTag = "R5";  wr(6'd53, 1, 0, 0, 64'h55, 32'h0); idle(2);
    wr(6'd54, 0, 1, 0, 64'd0, 32'h0000_0ABC); idle(2);
    curTag = "R10"; wr(6'd53, 0, 1, 1, 64'd0, 32'hFFC0_1234); idle(3);
    wr(6'd54, 0, 1, 1, 64'd0, 32'h003F_FFFF); idle(3);
    curTag = "R11"; wr(6'd53, 1, 1, 1, 64'h0000_0000_0000_0100, 32'h0000_00FF); idle(3);

    curTag = "R12"; wr(6'd54, 1, 0, 1, {10'd0, ALL1 - 54'd1}, 32'h0);
    rstN = 1'b0;
    @(negedge clk);
    resetChecks();
    @(negedge clk);
    resetChecks();
    #1 rstN = 1'b1;
    idle(6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule